// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit nanosecond time value that advances on every clock cycle while counting is enabled. Each cycle it normally adds a small programmable default step. Two compensation paths replace that step with a second programmable step so that software can trim the clock rate. The fast path applies the alternate step for a programmed number of consecutive ticks. The slow path is a periodic down-counter: on every R-th active tick it applies the alternate step once. Together they let software pull the time value toward a reference without stepping it.

Software reaches the block through a simple word register port. The port has write and read strobes, a 3-bit word address and 32-bit data. Read data is combinational from the address. Through this port software can set the configuration, load the compensation counts, write either half of the time value, read the time value coherently, and clear a sticky overflow flag. A compare unit elsewhere can force the time value to zero through a dedicated input. The running value is also driven out on a port for consumers on the chip.

The increment source is chosen by a three-state machine. ST_OFF means no counting. ST_NOMINAL means the default step, or the alternate step on a slow-compensation expiry. ST_FAST means the alternate step every tick. The transitions are as follows. ST_OFF goes to ST_NOMINAL when enable is set and the fast count is zero. ST_OFF goes to ST_FAST when enable is set and the fast count is nonzero. ST_NOMINAL goes to ST_FAST when the next fast count is nonzero. ST_FAST goes to ST_NOMINAL when the next fast count is zero. Both ST_NOMINAL and ST_FAST go to ST_OFF when enable is clear. The state register samples the registered enable, so counting starts and stops one cycle after the enable write.

Top module: `drift_time_counter`

## Requirements
- R1: After reset every readable register reads zero and counting is off. The registers are configuration (address 0), status (1), fast count (2), slow reload (3), time low word (4) and latched time high word (5).
- R2: The configuration word at address 0 holds enable at bit 0, the default step at bits 7:4 and the alternate step at bits 19:8. Other bits read as zero. While counting, with no compensation due, each tick adds the default step.
- R3: While counting is off, the time value and both compensation counters hold their values.
- R4: The fast count register (address 2, 24 bits, upper bits read zero) makes the next N active ticks add the alternate step. It decrements once per such tick, and the default step resumes when it reaches zero.
- R5: A nonzero slow reload R written at address 3 also loads the slow down-counter. Every R-th active tick then adds the alternate step instead of the default step.
- R6: A slow reload of zero disables slow compensation, so only the default step is added.
- R7: A read of the low time word (address 4) captures the high word in the same cycle. A later read of address 5 returns that captured high word even if the counter has since carried into the high word.
- R8: Status bit 0 (address 1) is set when an increment carries out of bit 63. It stays set until a write with bit 0 equal to 1, and writing 0 leaves it set.
- R9: A write to address 4 replaces only the low 32 bits of the time value. A write to address 5 replaces only the high 32 bits. A register write takes priority over the reset input and over the increment in the same cycle.
- R10: While the compare-reset input is high at a clock edge, the time value loads zero instead of incrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the low time word) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cmp_zero_rst | input | 1 | Counter reset request from compare channel 0 |
| time_now | output | 64 | Current time value |

## Verification
The bench measures exact tick counts across an enable window. If the one-cycle state lag were off, or the fast count were off by one, the totals would be 4 or more nanoseconds wrong. The slow path is checked for the expiry phase: a counter that expired on the first tick, or one tick late, would give a different number of alternate steps in ten ticks. A coherent-read test lets the low word carry into the high word between the two reads. A design that returns the live high word would then report 2 instead of 1. Overflow stickiness, write-zero-has-no-effect and a reset pulse in the middle of counting are each checked through the register port.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_NOMINAL = 2'd1,
        ST_FAST    = 2'd2
    } tc_state_e;

    localparam int unsigned REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_FAST   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_SLOW   = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_CNT_LO = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_CNT_HI = 3'd5;

    localparam int unsigned CFG_EN_BIT   = 0;
    localparam int unsigned CFG_DEF_LSB  = 4;
    localparam int unsigned CFG_COMP_LSB = 8;

endpackage

// File: rtl/tc_regs.sv
module tc_regs
    import tc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEF_W  = 4,
    parameter int unsigned COMP_W = 12,
    parameter int unsigned FAST_W = 24,
    parameter int unsigned SLOW_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  cfg_en,
    output logic [DEF_W-1:0]      def_inc,
    output logic [COMP_W-1:0]     comp_inc,
    output logic                  wr_fast,
    output logic                  wr_slow,
    output logic                  wr_lo,
    output logic                  wr_hi,
    output logic                  clr_ovf,
    output logic [DATA_W-1:0]     hi_latch,
    input  logic [FAST_W-1:0]     fast_cnt,
    input  logic [SLOW_W-1:0]     slow_reload,
    input  logic                  ovf,
    input  logic [2*DATA_W-1:0]   cnt_now
);

    localparam int unsigned CFG_TOP = CFG_COMP_LSB + COMP_W;

    logic wr_cfg;
    logic rd_lo;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^{reg_wdata[CFG_DEF_LSB-1:1], reg_wdata[DATA_W-1:CFG_TOP]};

    always_comb begin
        wr_cfg  = reg_wr && (reg_addr == A_CFG);
        wr_fast = reg_wr && (reg_addr == A_FAST);
        wr_slow = reg_wr && (reg_addr == A_SLOW);
        wr_lo   = reg_wr && (reg_addr == A_CNT_LO);
        wr_hi   = reg_wr && (reg_addr == A_CNT_HI);
        clr_ovf = reg_wr && (reg_addr == A_STATUS) && reg_wdata[0];
        rd_lo   = reg_rd && (reg_addr == A_CNT_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            def_inc  <= '0;
            comp_inc <= '0;
        end else if (wr_cfg) begin
            cfg_en   <= reg_wdata[CFG_EN_BIT];
            def_inc  <= reg_wdata[CFG_DEF_LSB +: DEF_W];
            comp_inc <= reg_wdata[CFG_COMP_LSB +: COMP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_latch <= '0;
        end else if (rd_lo) begin
            hi_latch <= cnt_now[2*DATA_W-1:DATA_W];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[CFG_EN_BIT]               = cfg_en;
                reg_rdata[CFG_DEF_LSB +: DEF_W]     = def_inc;
                reg_rdata[CFG_COMP_LSB +: COMP_W]   = comp_inc;
            end
            A_STATUS: reg_rdata[0]          = ovf;
            A_FAST:   reg_rdata[FAST_W-1:0] = fast_cnt;
            A_SLOW:   reg_rdata[SLOW_W-1:0] = slow_reload;
            A_CNT_LO: reg_rdata             = cnt_now[DATA_W-1:0];
            A_CNT_HI: reg_rdata             = hi_latch;
            default:  reg_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/tc_slow_comp.sv
module tc_slow_comp #(
    parameter int unsigned SLOW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              wr_slow,
    input  logic [SLOW_W-1:0] wdata,
    output logic [SLOW_W-1:0] reload_q,
    output logic              expire
);

    logic [SLOW_W-1:0] cnt_q;
    logic              armed;

    always_comb begin
        armed  = (reload_q != '0);
        expire = active && armed && (cnt_q == SLOW_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (wr_slow) begin
            reload_q <= wdata;
            cnt_q    <= wdata;
        end else if (active && armed) begin
            if (cnt_q == SLOW_W'(1)) begin
                cnt_q <= reload_q;
            end else begin
                cnt_q <= cnt_q - SLOW_W'(1);
            end
        end
    end

endmodule

// File: rtl/tc_mode_fsm.sv
module tc_mode_fsm
    import tc_pkg::*;
#(
    parameter int unsigned FAST_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              wr_fast,
    input  logic [FAST_W-1:0] fast_wdata,
    input  logic              slow_expire,
    output tc_state_e         state_q,
    output logic [FAST_W-1:0] fast_q,
    output logic              active,
    output logic              use_comp
);

    tc_state_e         state_d;
    logic [FAST_W-1:0] fast_d;

    always_comb begin
        if (wr_fast) begin
            fast_d = fast_wdata;
        end else if (state_q == ST_FAST) begin
            fast_d = fast_q - FAST_W'(1);
        end else begin
            fast_d = fast_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_en) begin
                    state_d = (fast_q != '0) ? ST_FAST : ST_NOMINAL;
                end
            end
            ST_NOMINAL: begin
                if (!cfg_en) begin
                    state_d = ST_OFF;
                end else if (fast_d != '0) begin
                    state_d = ST_FAST;
                end
            end
            ST_FAST: begin
                if (!cfg_en) begin
                    state_d = ST_OFF;
                end else if (fast_d == '0) begin
                    state_d = ST_NOMINAL;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            fast_q  <= '0;
        end else begin
            state_q <= state_d;
            fast_q  <= fast_d;
        end
    end

    always_comb begin
        active   = 1'b0;
        use_comp = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                active   = 1'b0;
                use_comp = 1'b0;
            end
            ST_NOMINAL: begin
                active   = 1'b1;
                use_comp = slow_expire;
            end
            ST_FAST: begin
                active   = 1'b1;
                use_comp = 1'b1;
            end
            default: begin
                active   = 1'b0;
                use_comp = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned INC_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic [INC_W-1:0]    inc,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                cmp_rst,
    input  logic                clr_ovf,
    output logic [2*DATA_W-1:0] cnt_q,
    output logic                ovf_q
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W:0] sum;
    logic           any_wr;
    logic           set_ovf;

    always_comb begin
        sum     = {1'b0, cnt_q} + (CNT_W + 1)'(inc);
        any_wr  = wr_lo || wr_hi;
        set_ovf = active && sum[CNT_W] && !any_wr && !cmp_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (cmp_rst) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (set_ovf) begin
            ovf_q <= 1'b1;
        end else if (clr_ovf) begin
            ovf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/drift_time_counter.sv
module drift_time_counter
    import tc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEF_W  = 4,
    parameter int unsigned COMP_W = 12,
    parameter int unsigned FAST_W = 24,
    parameter int unsigned SLOW_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  cmp_zero_rst,
    output logic [2*DATA_W-1:0]   time_now
);

    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam int unsigned INC_W = (COMP_W > DEF_W) ? COMP_W : DEF_W;

    logic              cfg_en;
    logic [DEF_W-1:0]  def_inc;
    logic [COMP_W-1:0] comp_inc;
    logic              wr_fast;
    logic              wr_slow;
    logic              wr_lo;
    logic              wr_hi;
    logic              clr_ovf;
    logic [DATA_W-1:0] hi_latch;
    logic [FAST_W-1:0] fast_q;
    logic [SLOW_W-1:0] slow_reload;
    logic              slow_expire;
    logic              ovf_q;
    logic [CNT_W-1:0]  cnt_q;
    tc_state_e         state_q;
    logic              active;
    logic              use_comp;
    logic [INC_W-1:0]  inc;

    tc_regs #(
        .DATA_W (DATA_W),
        .DEF_W  (DEF_W),
        .COMP_W (COMP_W),
        .FAST_W (FAST_W),
        .SLOW_W (SLOW_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cfg_en      (cfg_en),
        .def_inc     (def_inc),
        .comp_inc    (comp_inc),
        .wr_fast     (wr_fast),
        .wr_slow     (wr_slow),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .clr_ovf     (clr_ovf),
        .hi_latch    (hi_latch),
        .fast_cnt    (fast_q),
        .slow_reload (slow_reload),
        .ovf         (ovf_q),
        .cnt_now     (cnt_q)
    );

    tc_mode_fsm #(
        .FAST_W (FAST_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .wr_fast     (wr_fast),
        .fast_wdata  (reg_wdata[FAST_W-1:0]),
        .slow_expire (slow_expire),
        .state_q     (state_q),
        .fast_q      (fast_q),
        .active      (active),
        .use_comp    (use_comp)
    );

    tc_slow_comp #(
        .SLOW_W (SLOW_W)
    ) u_slow (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .wr_slow  (wr_slow),
        .wdata    (reg_wdata[SLOW_W-1:0]),
        .reload_q (slow_reload),
        .expire   (slow_expire)
    );

    always_comb begin
        inc = use_comp ? INC_W'(comp_inc) : INC_W'(def_inc);
    end

    tc_accum #(
        .DATA_W (DATA_W),
        .INC_W  (INC_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .inc     (inc),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (reg_wdata),
        .cmp_rst (cmp_zero_rst),
        .clr_ovf (clr_ovf),
        .cnt_q   (cnt_q),
        .ovf_q   (ovf_q)
    );

    assign time_now = cnt_q;

endmodule

// File: rtl/tc_checker.sv
module tc_checker
    import tc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEF_W  = 4,
    parameter int unsigned FAST_W = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input tc_state_e             state_q,
    input logic [FAST_W-1:0]     fast_q,
    input logic                  wr_fast,
    input logic                  wr_lo,
    input logic                  wr_hi,
    input logic                  clr_ovf,
    input logic                  cmp_rst,
    input logic                  slow_expire,
    input logic [DEF_W-1:0]      def_inc,
    input logic [2*DATA_W-1:0]   cnt_q,
    input logic                  ovf_q,
    input logic                  reg_rd,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0]     hi_latch
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !wr_lo && !wr_hi && !cmp_rst) |=> $stable(cnt_q)); // R3

    AST_DEFAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOMINAL && !slow_expire && !wr_lo && !wr_hi && !cmp_rst)
        |=> cnt_q == $past(cnt_q) + CNT_W'($past(def_inc))); // R2

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAST && !wr_fast) |=> fast_q == $past(fast_q) - FAST_W'(1)); // R4

    AST_FAST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAST) |-> (fast_q != '0)); // R4

    AST_CMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_rst && !wr_lo && !wr_hi) |=> (cnt_q == '0)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q); // R8

    AST_HI_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CNT_LO) |=> hi_latch == $past(cnt_q[CNT_W-1:DATA_W])); // R7

endmodule

bind drift_time_counter tc_checker #(
    .DATA_W (DATA_W),
    .DEF_W  (DEF_W),
    .FAST_W (FAST_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .fast_q      (fast_q),
    .wr_fast     (wr_fast),
    .wr_lo       (wr_lo),
    .wr_hi       (wr_hi),
    .clr_ovf     (clr_ovf),
    .cmp_rst     (cmp_zero_rst),
    .slow_expire (slow_expire),
    .def_inc     (def_inc),
    .cnt_q       (cnt_q),
    .ovf_q       (ovf_q),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .hi_latch    (hi_latch)
);

// File: tb/tb_drift_time_counter.sv
`timescale 1ns/100ps
module tb_drift_time_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmp_zero_rst = 1'b0;
    logic [63:0] time_now;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [2:0] CFG = 3'd0, STA = 3'd1, FST = 3'd2, SLW = 3'd3, LO = 3'd4, HI = 3'd5;

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expd;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{3'd0, 32'hFFF0_FFFE, 32'h0000_FFF0, 4'd2},  // R2 field masking, enable clear
        '{3'd0, 32'h1234_5678, 32'h0004_5670, 4'd2},  // R2
        '{3'd2, 32'hFFFF_FFFF, 32'h00FF_FFFF, 4'd4},  // R4 24-bit field
        '{3'd2, 32'h0000_0000, 32'h0000_0000, 4'd4},  // R4
        '{3'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd5},  // R5
        '{3'd3, 32'h0000_0000, 32'h0000_0000, 4'd6},  // R6
        '{3'd4, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'd9},  // R9
        '{3'd1, 32'h0000_0001, 32'h0000_0000, 4'd8}   // R8
    };

    drift_time_counter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cmp_zero_rst (cmp_zero_rst),
        .time_now     (time_now)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_cnt(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(LO, lo);
        rd(HI, hi);
        v = {hi, lo};
    endtask

    function automatic logic [31:0] cfgw(input int c, input int d, input bit en);
        return (32'(c) << 8) | (32'(d) << 4) | 32'(en);
    endfunction

    // Enable, let n more cycles pass, disable: exactly n+1 active ticks.
    task automatic run_ticks(input int c, input int d, input int n);
        wr(CFG, cfgw(c, d, 1'b1));
        repeat (n) @(negedge clk);
        wr(CFG, cfgw(c, d, 1'b0));
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_cnt();
        wr(LO, 32'h0);
        wr(HI, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d, lo1;
        logic [63:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), d);
            check($sformatf("R1 reset read addr %0d", i), 64'(d), 64'h0);
        end
        check("R1 time_now at reset", time_now, 64'h0);

        // Register vector table
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, d);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(d), 64'(VECS[i].expd));
        end

        // R2 default step: 10 ticks of 5
        clr_cnt();
        run_ticks(0, 5, 9);
        rd_cnt(v);
        check("R2 default step total", v, 64'd50);
        // R3 hold while off
        repeat (5) @(negedge clk);
        rd_cnt(v);
        check("R3 count held while off", v, 64'd50);

        // R4 fast compensation: 3 ticks of 10, then 7 of 4
        clr_cnt();
        wr(FST, 32'd3);
        repeat (4) @(negedge clk);
        rd(FST, d);
        check("R3 fast count held while off", 64'(d), 64'd3);
        run_ticks(10, 4, 9);
        rd_cnt(v);
        check("R4 fast compensation total", v, 64'd58);
        rd(FST, d);
        check("R4 fast count drained", 64'(d), 64'd0);

        // R5 slow compensation: reload 4, ticks 4 and 8 use 5, rest use 4
        clr_cnt();
        wr(SLW, 32'd4);
        run_ticks(5, 4, 9);
        rd_cnt(v);
        check("R5 slow compensation total", v, 64'd42);

        // R6 reload zero disables slow path
        clr_cnt();
        wr(SLW, 32'd0);
        run_ticks(9, 4, 9);
        rd_cnt(v);
        check("R6 slow disabled total", v, 64'd40);

        // R7 coherent read across a carry into the high word
        wr(HI, 32'h1);
        wr(LO, 32'hFFFF_FFF0);
        wr(CFG, cfgw(0, 15, 1'b1));
        rd(LO, lo1);
        repeat (3) @(negedge clk);
        rd(HI, d);
        check("R7 low word read", 64'(lo1), 64'hFFFF_FFF0);
        check("R7 latched high word", 64'(d), 64'h1);
        wr(CFG, cfgw(0, 15, 1'b0));
        repeat (3) @(negedge clk);
        rd_cnt(v);
        check("R7 high word after carry", 64'(v[63:32]), 64'h2);

        // R8 overflow: one tick of 10 from 2^64-8
        wr(STA, 32'h1);
        wr(HI, 32'hFFFF_FFFF);
        wr(LO, 32'hFFFF_FFF8);
        run_ticks(0, 10, 0);
        rd(STA, d);
        check("R8 overflow flag set", 64'(d), 64'h1);
        rd_cnt(v);
        check("R8 wrapped value", v, 64'd2);
        wr(STA, 32'h0);
        rd(STA, d);
        check("R8 write 0 leaves flag", 64'(d), 64'h1);
        wr(STA, 32'h1);
        rd(STA, d);
        check("R8 write 1 clears flag", 64'(d), 64'h0);

        // R9 high half write leaves low half
        wr(HI, 32'hAAAA_5555);
        rd_cnt(v);
        check("R9 independent halves", v, 64'hAAAA_5555_0000_0002);
        check("R9 time_now port", time_now, 64'hAAAA_5555_0000_0002);

        // R10 compare reset in the middle of counting
        clr_cnt();
        wr(LO, 32'h1000);
        wr(CFG, cfgw(0, 3, 1'b1));
        repeat (3) @(negedge clk);
        cmp_zero_rst = 1'b1;
        @(negedge clk);
        cmp_zero_rst = 1'b0;
        repeat (2) @(negedge clk);
        wr(CFG, cfgw(0, 3, 1'b0));
        repeat (3) @(negedge clk);
        rd_cnt(v);
        check("R10 reset then four ticks", v, 64'd12);

        finish_run();
    end

endmodule